// File: doc/BRIEF.md
# Debounced Pin Interrupt Detector

This block turns the input levels of a general-purpose I/O port into interrupt requests. Each pin passes through a two-flop synchronizer. It may then go through a debounce sampler that only takes a new value on a periodic sample strobe. A per-pin trigger setting compares the resulting level against a rising-edge, falling-edge, both-edge, high-level or low-level condition. A match sets a sticky per-pin status flag. The enabled flags are ORed into one registered interrupt line.

The sample strobe is counted in ticks of one of two sources. One source is the system clock, where every cycle is a tick. The other is a slow tick input, produced elsewhere as a single-cycle pulse. The period is 2^N ticks, with N taken from a 4-bit select. The debounce setting applies only to the interrupt path.

A global "track always" control decides how a pin's edge history behaves while the pin has no trigger enabled. When it is set, the history keeps updating. When it is clear, the history is frozen, so a change that happened while the pin was disabled is reported once as an edge when the pin is enabled.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset, `status` and `irq` are both 0.
- R2: A pin with `rise_high_en`=1, `fall_low_en`=0 and `level_mode`=0 sets its status bit on a 0-to-1 change of its sampled level, and not on a 1-to-0 change. For an undebounced pin, the status bit reads 1 on the 4th rising clock edge after the pin changes, and `irq` follows one cycle later.
- R3: A pin with `fall_low_en`=1, `rise_high_en`=0 and `level_mode`=0 sets its status bit on a 1-to-0 change only.
- R4: A pin with both enables set and `level_mode`=0 sets its status bit on every change of its sampled level.
- R5: With `level_mode`=1, the status bit is set in every cycle in which the sampled level is 1 (if `rise_high_en` is set) or 0 (if `fall_low_en` is set). A clear that arrives while the level still matches is overridden, and the bit stays 1.
- R6: Status bits stay set until a cycle in which the matching bit of `status_clr` is 1. Bits of `status_clr` that are 0 leave their flags unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R7: `irq` is a register that takes the OR over all pins of (status bit AND (`rise_high_en` OR `fall_low_en`)). A pin with both enables cleared keeps its status bit but does not drive `irq`.
- R8: A pin with `dbc_en`=1 changes its sampled level only on a debounce strobe. With the slow source selected and no ticks arriving, level changes on that pin are not seen.
- R9: The debounce strobe fires on every 2^`dbc_sel` th tick of the selected source. `dbc_slow_src`=0 counts system clock cycles, and `dbc_slow_src`=1 counts cycles with `slow_tick`=1. With the slow source selected from reset and `dbc_sel`=2, the first strobe comes on the 4th tick.
- R10: With `track_all`=0, a pin whose enables are both 0 keeps its previous sampled level frozen. Enabling it afterwards reports a change made meanwhile as an edge. With `track_all`=1, the history keeps updating, so no such stale edge appears.
- R11: A pin with `dbc_en`=0 uses the synchronized level directly, whether or not strobes occur.
- R12: All pins are detected independently and at the same time, each with its own trigger setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Raw pin levels (asynchronous) |
| slow_tick | input | 1 | One-cycle pulse from the slow debounce source |
| dbc_slow_src | input | 1 | Debounce tick source: 0 = system clock, 1 = `slow_tick` |
| dbc_sel | input | 4 | Debounce period exponent, period = 2^dbc_sel ticks |
| track_all | input | 1 | Keep edge history updating on all pins |
| dbc_en | input | NPINS | Per-pin debounce enable |
| fall_low_en | input | NPINS | Per-pin falling-edge / low-level detect enable |
| rise_high_en | input | NPINS | Per-pin rising-edge / high-level detect enable |
| level_mode | input | NPINS | Per-pin trigger type: 1 = level, 0 = edge |
| status_clr | input | NPINS | Write-one-to-clear strobe for status flags |
| status | output | NPINS | Sticky pending flags |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The hardest state to reach is a debounced pin whose level has changed but whose sampler has not yet been strobed. Its observable behaviour depends on the phase of a free-running counter. The bench fixes that phase by resetting with the slow source selected and driving every tick itself. It can then count exactly how many ticks remain before the sampler accepts the new level. The stale-edge case of the frozen history is also hard to reach. It is produced by changing a disabled pin's level and enabling the pin only afterwards, once with history tracking on and once with it off.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  // width of the period exponent and of the tick counter it implies
  localparam int unsigned DBC_SEL_W = 4;
  localparam int unsigned DBC_CNT_W = (1 << DBC_SEL_W) - 1;

  // last counter value of a debounce period of 2^sel ticks
  function automatic logic [DBC_CNT_W-1:0] dbc_last(input logic [DBC_SEL_W-1:0] sel);
    logic [DBC_CNT_W:0] one_hot;
    one_hot = (DBC_CNT_W + 1)'(1) << sel;
    return DBC_CNT_W'(one_hot - 1'b1);
  endfunction

  // trigger match for one pin given current and previous sampled levels
  function automatic logic trig_match(input logic lvl_type, input logic hi_en,
                                      input logic lo_en, input logic cur,
                                      input logic prv);
    if (lvl_type) begin
      return (hi_en & cur) | (lo_en & ~cur);
    end
    return (hi_en & cur & ~prv) | (lo_en & ~cur & prv);
  endfunction

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pin_irq_dbc_timer.sv
module pin_irq_dbc_timer
  import pin_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slow_src,
  input  logic                 slow_tick,
  input  logic [DBC_SEL_W-1:0] sel,
  output logic                 strobe
);

  logic [DBC_CNT_W-1:0] cnt_q;
  logic                 tick;
  logic                 at_last;

  assign tick    = slow_src ? slow_tick : 1'b1;
  // >= so that shrinking the period mid-count wraps at once
  assign at_last = (cnt_q >= dbc_last(sel));
  assign strobe  = tick & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end

  AST_DBC_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= dbc_last(sel)) |=> (cnt_q <= dbc_last($past(sel)))); // R9

  AST_DBC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_src && !slow_tick) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/pin_irq_pin_det.sv
module pin_irq_pin_det
  import pin_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_lvl,
  input  logic dbc_on,
  input  logic dbc_strobe,
  input  logic track,
  input  logic lvl_type,
  input  logic hi_en,
  input  logic lo_en,
  output logic hit
);

  logic lvl_q;
  logic prev_q;

  // sampled level: every cycle when undebounced, on strobes otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (!dbc_on || dbc_strobe) begin
      lvl_q <= sync_lvl;
    end
  end

  // edge history, frozen while the pin is not tracked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else if (track) begin
      prev_q <= lvl_q;
    end
  end

  assign hit = trig_match(lvl_type, hi_en, lo_en, lvl_q, prev_q);

  AST_DBC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dbc_on && !dbc_strobe) |=> $stable(lvl_q)); // R8

  AST_RAW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !dbc_on |=> (lvl_q == $past(sync_lvl))); // R11

  AST_HIST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !track |=> $stable(prev_q)); // R10

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPINS-1:0]     pin_in,
  input  logic                 slow_tick,
  input  logic                 dbc_slow_src,
  input  logic [DBC_SEL_W-1:0] dbc_sel,
  input  logic                 track_all,
  input  logic [NPINS-1:0]     dbc_en,
  input  logic [NPINS-1:0]     fall_low_en,
  input  logic [NPINS-1:0]     rise_high_en,
  input  logic [NPINS-1:0]     level_mode,
  input  logic [NPINS-1:0]     status_clr,
  output logic [NPINS-1:0]     status,
  output logic                 irq
);

  logic [NPINS-1:0] sync_lvl;
  logic [NPINS-1:0] pin_act;
  logic [NPINS-1:0] pin_track;
  logic [NPINS-1:0] hit_vec;
  logic             dbc_strobe;
  logic [NPINS-1:0] status_q;
  logic             irq_q;

  assign pin_act   = fall_low_en | rise_high_en;
  assign pin_track = {NPINS{track_all}} | pin_act;

  pin_irq_sync #(
    .WIDTH  (NPINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (sync_lvl)
  );

  pin_irq_dbc_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_src  (dbc_slow_src),
    .slow_tick (slow_tick),
    .sel       (dbc_sel),
    .strobe    (dbc_strobe)
  );

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      pin_irq_pin_det u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_lvl   (sync_lvl[p]),
        .dbc_on     (dbc_en[p]),
        .dbc_strobe (dbc_strobe),
        .track      (pin_track[p]),
        .lvl_type   (level_mode[p]),
        .hi_en      (rise_high_en[p]),
        .lo_en      (fall_low_en[p]),
        .hit        (hit_vec[p])
      );
    end
  endgenerate

  // sticky flags: a new match outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~status_clr) | hit_vec;
      irq_q    <= |(status_q & pin_act);
    end
  end

  assign status = status_q;
  assign irq    = irq_q;

  AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |=> ((status_q & $past(hit_vec)) == $past(hit_vec))); // R2

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_clr & ~hit_vec) != '0) |=> ((status_q & $past(status_clr & ~hit_vec)) == '0)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~status_clr) != '0)
      |=> ((status_q & $past(status_q & ~status_clr)) == $past(status_q & ~status_clr))); // R6

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & pin_act)) |=> irq_q); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_q & pin_act)) |=> !irq_q); // R7

endmodule

// File: tb/test_pin_irq_detect.sv
module test_pin_irq_detect;

  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pins, dbe, fl, rh, lm, clr;
  logic          tick, src, trk;
  logic [3:0]    sel;
  logic [NP-1:0] status;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pin_irq_detect #(.NPINS(NP), .SYNC_STAGES(2)) i_pin_irq_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_in       (pins),
    .slow_tick    (tick),
    .dbc_slow_src (src),
    .dbc_sel      (sel),
    .track_all    (trk),
    .dbc_en       (dbe),
    .fall_low_en  (fl),
    .rise_high_en (rh),
    .level_mode   (lm),
    .status_clr   (clr),
    .status       (status),
    .irq          (irq)
  );

  // expected flag from mode {level, rise/high, fall/low}, old and new level
  function automatic logic exp_hit(input logic [2:0] m, input logic o, input logic n);
    case (m)
      3'b010:  return !o && n;
      3'b001:  return o && !n;
      3'b011:  return o != n;
      3'b110:  return n;
      3'b101:  return !n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] mode_of(input int k);
    case (k)
      0: return 3'b010;
      1: return 3'b001;
      2: return 3'b011;
      3: return 3'b110;
      default: return 3'b101;
    endcase
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pins = '0; dbe = '0; fl = '0; rh = '0; lm = '0; clr = '0;
    tick = 1'b0; src = 1'b1; sel = 4'd2; trk = 1'b1;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic clear(input logic [NP-1:0] m);
    clr = m;
    cyc(1);
    clr = '0;
  endtask

  task automatic one_tick();
    tick = 1'b1;
    cyc(1);
    tick = 1'b0;
    cyc(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd5150));
    do_reset();
    // R1 reset state
    chk("R1 status", 32'(status), 0);
    chk("R1 irq", 32'(irq), 0);

    // R8 / R9 / R11: slow source from reset, period 4 ticks
    rh[1] = 1'b1; dbe[1] = 1'b1;
    rh[2] = 1'b1;
    pins[1] = 1'b1; pins[2] = 1'b1;
    cyc(8);
    chk("R8 debounced pin unseen without ticks", 32'(status[1]), 0);
    chk("R11 undebounced pin seen", 32'(status[2]), 1);
    repeat (3) one_tick();
    cyc(4);
    chk("R9 no strobe before 4th tick", 32'(status[1]), 0);
    one_tick();
    cyc(4);
    chk("R9 strobe on 4th tick", 32'(status[1]), 1);
    src = 1'b0; sel = 4'd0;
    pins[1] = 1'b0;
    cyc(8);
    clear('1);
    pins[1] = 1'b1;
    cyc(8);
    chk("R9 system clock every cycle", 32'(status[1]), 1);

    // edge modes
    do_reset();
    rh[0] = 1'b1; fl[1] = 1'b1; rh[2] = 1'b1; fl[2] = 1'b1;
    pins[2:0] = 3'b111;
    cyc(8);
    chk("R2/R4 rising", 32'(status[2:0]), 3'b101);
    clear('1);
    cyc(2);
    chk("R6 clear all", 32'(status), 0);
    pins[2:0] = 3'b000;
    cyc(8);
    chk("R3/R4 falling", 32'(status[2:0]), 3'b110);
    // R2 latency and R7 timing
    pins[0] = 1'b1;
    cyc(3);
    chk("R2 not yet set", 32'(status[0]), 0);
    cyc(1);
    chk("R2 set on 4th edge", 32'(status[0]), 1);
    clear(3'b110);
    chk("R7 irq next cycle", 32'(irq), 1);
    cyc(2);
    chk("R6 partial clear", 32'(status[2:0]), 3'b001);
    clear('0);
    cyc(1);
    chk("R6 zero clear no effect", 32'(status[2:0]), 3'b001);
    rh[0] = 1'b0;
    cyc(3);
    chk("R7 masked irq", 32'(irq), 0);
    chk("R7 flag kept", 32'(status[0]), 1);

    // R10 frozen history
    do_reset();
    trk = 1'b0;
    pins[3] = 1'b1;
    cyc(8);
    rh[3] = 1'b1;
    cyc(6);
    chk("R10 stale edge when frozen", 32'(status[3]), 1);
    rh[3] = 1'b0;
    clear('1);
    trk = 1'b1;
    pins[3] = 1'b0;
    cyc(8);
    pins[3] = 1'b1;
    cyc(8);
    rh[3] = 1'b1;
    cyc(6);
    chk("R10 no stale edge when tracking", 32'(status[3]), 0);

    // R5 level modes
    do_reset();
    lm[5] = 1'b1; rh[5] = 1'b1;
    lm[6] = 1'b1; fl[6] = 1'b1;
    pins[5] = 1'b1;
    cyc(6);
    chk("R5 both levels match", 32'(status[6:5]), 2'b11);
    clear(8'h60);
    chk("R5 clear overridden", 32'(status[6:5]), 2'b11);
    pins[5] = 1'b0; pins[6] = 1'b1;
    cyc(6);
    clear(8'h60);
    cyc(2);
    chk("R5 clear sticks after level gone", 32'(status[6:5]), 2'b00);

    // R12 random modes on all pins
    do_reset();
    begin
      logic [2:0]    md [NP];
      logic [NP-1:0] old_v, new_v, expv;
      for (int p = 0; p < NP; p++) begin
        md[p] = mode_of(int'($urandom_range(0, 4)));
        lm[p] = md[p][2]; rh[p] = md[p][1]; fl[p] = md[p][0];
      end
      cyc(6);
      old_v = '0;
      expv = '0;
      for (int p = 0; p < NP; p++) expv[p] = exp_hit(md[p], 1'b0, 1'b0);
      chk("R12 initial levels", 32'(status), 32'(expv));
      for (int st = 0; st < 40; st++) begin
        new_v = NP'($urandom);
        pins = new_v;
        cyc(7);
        for (int p = 0; p < NP; p++) expv[p] = expv[p] | exp_hit(md[p], old_v[p], new_v[p]);
        chk("R12 random step", 32'(status), 32'(expv));
        chk("R12 random irq", 32'(irq), 32'(|expv));
        if (st % 5 == 4) begin
          clear('1);
          cyc(1);
          for (int p = 0; p < NP; p++) expv[p] = md[p][2] & exp_hit(md[p], new_v[p], new_v[p]);
          chk("R12 after clear", 32'(status), 32'(expv));
        end
        old_v = new_v;
      end
    end

    finish_run();
  end

endmodule